// File: doc/BRIEF.md
# Voice Interrupt Priority Queue

The block collects interrupt events raised by up to 32 synthesizer voices into two pending masks: one for wavetable loop/end events and one for volume-ramp events. Voices raise an event with a one-cycle set pulse on the matching bit of `wt_set_i` or `vr_set_i`. The host drains the queue one entry at a time. Each time it writes the dequeue code 0x8F to the function-select register, the block services one pending voice. It clears that voice's pending bit and pulses an acknowledge line, which the voice uses to drop its own interrupt flag. It also latches an identification byte that the host reads back.

Wavetable events have strict priority over volume-ramp events. Within a class, the lowest-numbered voice wins, and only voices 0 to 30 can be serviced. In the identification byte a cleared class bit marks the class being reported, so 0x60|voice reports a wavetable voice, 0x80|voice reports a volume-ramp voice and 0xE8 reports that nothing was serviced. The block keeps two summary bits in the card interrupt status byte and drives the interrupt line from that byte. A write to the reset control bit with the value 0 flushes both masks and the status.

Top module: `voice_irq_queue`

## Requirements
- R1: A dequeue happens only on a write of 0x8F to the function-select input (`fsel_we_i`=1, `fsel_data_i`=8'h8F). A write of any other value leaves the masks, the identification byte and the acknowledge outputs unchanged.
- R2: On a dequeue while `wt_pend_o` is nonzero, the block takes the lowest set bit v among bits 0..30. In the cycle after the write, bit v of `wt_pend_o` is clear, `wt_ack_o` is the one-hot value 1<<v for one cycle, and `irq_id_o` = 8'h60 | v.
- R3: Volume-ramp events are serviced only when `wt_pend_o` is zero. The lowest set bit v among 0..30 of `vr_pend_o` is cleared, `vr_ack_o` = 1<<v for one cycle, and `irq_id_o` = 8'h80 | v. At most one acknowledge output is nonzero in any cycle.
- R4: A dequeue with both masks zero sets `irq_id_o` to 8'hE8 and pulses no acknowledge.
- R5: When `wt_pend_o` holds only bit 31, a dequeue sets `irq_id_o` to 8'hE8, clears nothing and leaves the volume-ramp mask untouched.
- R6: Status bit 5 of `irq_stat_o` is set by any wavetable set pulse and cleared when a dequeue empties the wavetable mask. Bit 6 does the same for the volume-ramp mask. All other status bits are 0, and `irq_o` is high exactly when `irq_stat_o` is nonzero.
- R7: A set pulse on bit v sets that pending bit one cycle later. A set pulse on the voice being dequeued in the same cycle wins, so that bit stays pending while the acknowledge still pulses.
- R8: A write of `ctrl_run_i`=0 (`ctrl_we_i`=1) clears both masks and the status one cycle later, overrides set pulses and a dequeue in that cycle, and leaves `irq_id_o` unchanged. A write with `ctrl_run_i`=1 has no effect.
- R9: While `rst_ni` is low, both masks, the acknowledges and the status are zero, `irq_o` is low and `irq_id_o` is 8'hE8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsel_we_i | input | 1 | Function-select register write strobe |
| fsel_data_i | input | 8 | Function-select write data; 8'h8F dequeues |
| ctrl_we_i | input | 1 | Reset control register write strobe |
| ctrl_run_i | input | 1 | Run bit written with the strobe; 0 flushes the queue |
| wt_set_i | input | NUM_VOICES | Wavetable event set pulses, one per voice |
| vr_set_i | input | NUM_VOICES | Volume-ramp event set pulses, one per voice |
| wt_pend_o | output | NUM_VOICES | Wavetable pending mask |
| vr_pend_o | output | NUM_VOICES | Volume-ramp pending mask |
| wt_ack_o | output | NUM_VOICES | One-hot pulse clearing the serviced voice's wavetable flag |
| vr_ack_o | output | NUM_VOICES | One-hot pulse clearing the serviced voice's volume-ramp flag |
| irq_id_o | output | 8 | Identification byte of the last dequeue |
| irq_stat_o | output | 8 | Interrupt status byte (bits 5 and 6 maintained here) |
| irq_o | output | 1 | Interrupt line, high while the status is nonzero |

## Verification
Two functions can land in the same cycle: a voice raising an event and the host dequeuing that same voice, and also a flush together with both of them. The bench provokes the first case directly by pulsing the set bit of the voice about to be serviced during the 0x8F write. It then expects the acknowledge and the identification byte to report the voice while its pending bit stays set. Random runs with dense dequeue writes, sparse set pulses and rare flush writes produce further collisions. Each one is judged against a cycle model in the bench, where a flush overrides everything and a set overrides a clear.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam logic [7:0] DEQ_CODE   = 8'h8F;
  localparam logic [7:0] ID_WT_BASE = 8'h60;
  localparam logic [7:0] ID_VR_BASE = 8'h80;
  localparam logic [7:0] ID_NONE    = 8'hE8;
  localparam int unsigned STAT_WT_BIT = 5;
  localparam int unsigned STAT_VR_BIT = 6;
  localparam int unsigned CLS_WT = 0;
  localparam int unsigned CLS_VR = 1;
  localparam int unsigned NUM_CLS = 2;
endpackage

// File: rtl/voice_irq_pick.sv
// Lowest-set-bit selector limited to the first SCAN bits.
module voice_irq_pick #(
  parameter int unsigned W     = 32,
  parameter int unsigned SCAN  = 31,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [W-1:0]     onehot_o
);
  logic [W-1:0] scan_m;
  logic [W-1:0] masked;

  for (genvar g = 0; g < W; g++) begin : g_scan
    assign scan_m[g] = (g < SCAN);
  end

  assign masked   = req_i & scan_m;
  assign onehot_o = masked & (~masked + W'(1));
  assign found_o  = |masked;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/voice_irq_class.sv
// One pending mask with its status summary flag.
module voice_irq_class #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [W-1:0] set_i,
  input  logic         take_i,
  input  logic [W-1:0] take_mask_i,
  output logic [W-1:0] pend_o,
  output logic         sum_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] kept;
  logic         sum_q;

  assign kept = pend_q & ~(take_i ? take_mask_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      sum_q  <= 1'b0;
    end else if (flush_i) begin
      pend_q <= '0;
      sum_q  <= 1'b0;
    end else begin
      pend_q <= kept | set_i;  // set beats clear
      if (|set_i)                    sum_q <= 1'b1;
      else if (take_i && kept == '0) sum_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign sum_o  = sum_q;
endmodule

// File: rtl/voice_irq_queue.sv
module voice_irq_queue
  import voice_irq_pkg::*;
#(
  parameter int unsigned NUM_VOICES  = 32,
  parameter int unsigned SCAN_VOICES = 31
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fsel_we_i,
  input  logic [7:0]            fsel_data_i,
  input  logic                  ctrl_we_i,
  input  logic                  ctrl_run_i,
  input  logic [NUM_VOICES-1:0] wt_set_i,
  input  logic [NUM_VOICES-1:0] vr_set_i,
  output logic [NUM_VOICES-1:0] wt_pend_o,
  output logic [NUM_VOICES-1:0] vr_pend_o,
  output logic [NUM_VOICES-1:0] wt_ack_o,
  output logic [NUM_VOICES-1:0] vr_ack_o,
  output logic [7:0]            irq_id_o,
  output logic [7:0]            irq_stat_o,
  output logic                  irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_VOICES);

  logic flush, deq;
  logic [NUM_CLS-1:0][NUM_VOICES-1:0] set_bus, pend_bus, pick_bus;
  logic [NUM_CLS-1:0][IDX_W-1:0]      idx_bus;
  logic [NUM_CLS-1:0]                 found_bus, take_bus, sum_bus, any_bus;

  assign flush = ctrl_we_i & ~ctrl_run_i;
  assign deq   = fsel_we_i & (fsel_data_i == DEQ_CODE) & ~flush;

  assign set_bus[CLS_WT] = wt_set_i;
  assign set_bus[CLS_VR] = vr_set_i;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign any_bus[c] = |pend_bus[c];

    voice_irq_pick #(.W(NUM_VOICES), .SCAN(SCAN_VOICES), .IDX_W(IDX_W)) u_pick (
      .req_i    (pend_bus[c]),
      .found_o  (found_bus[c]),
      .idx_o    (idx_bus[c]),
      .onehot_o (pick_bus[c])
    );

    voice_irq_class #(.W(NUM_VOICES)) u_cls (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush),
      .set_i       (set_bus[c]),
      .take_i      (take_bus[c]),
      .take_mask_i (pick_bus[c]),
      .pend_o      (pend_bus[c]),
      .sum_o       (sum_bus[c])
    );
  end

  // wavetable class owns the queue whenever its mask is nonzero, even if unservable
  assign take_bus[CLS_WT] = deq & any_bus[CLS_WT] & found_bus[CLS_WT];
  assign take_bus[CLS_VR] = deq & ~any_bus[CLS_WT] & any_bus[CLS_VR] & found_bus[CLS_VR];

  logic [7:0] id_d, id_q;
  logic [NUM_VOICES-1:0] wt_ack_q, vr_ack_q;

  always_comb begin
    id_d = ID_NONE;
    if (take_bus[CLS_WT])      id_d = ID_WT_BASE | 8'(idx_bus[CLS_WT]);
    else if (take_bus[CLS_VR]) id_d = ID_VR_BASE | 8'(idx_bus[CLS_VR]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q     <= ID_NONE;
      wt_ack_q <= '0;
      vr_ack_q <= '0;
    end else begin
      if (deq) id_q <= id_d;
      wt_ack_q <= take_bus[CLS_WT] ? pick_bus[CLS_WT] : '0;
      vr_ack_q <= take_bus[CLS_VR] ? pick_bus[CLS_VR] : '0;
    end
  end

  always_comb begin
    irq_stat_o = '0;
    irq_stat_o[STAT_WT_BIT] = sum_bus[CLS_WT];
    irq_stat_o[STAT_VR_BIT] = sum_bus[CLS_VR];
  end

  assign irq_o     = |irq_stat_o;
  assign wt_pend_o = pend_bus[CLS_WT];
  assign vr_pend_o = pend_bus[CLS_VR];
  assign wt_ack_o  = wt_ack_q;
  assign vr_ack_o  = vr_ack_q;
  assign irq_id_o  = id_q;
endmodule

// File: rtl/voice_irq_queue_chk.sv
module voice_irq_queue_chk #(
  parameter int unsigned NUM_VOICES = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fsel_we_i,
  input logic [7:0]            fsel_data_i,
  input logic [NUM_VOICES-1:0] wt_pend_o,
  input logic [NUM_VOICES-1:0] vr_pend_o,
  input logic [NUM_VOICES-1:0] wt_ack_o,
  input logic [NUM_VOICES-1:0] vr_ack_o,
  input logic [7:0]            irq_stat_o,
  input logic                  irq_o
);
  // R1
  ack_needs_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wt_ack_o || |vr_ack_o) |-> $past(fsel_we_i && fsel_data_i == 8'h8F));

  // R2
  wt_ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wt_ack_o));

  // R2
  wt_ack_was_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wt_ack_o) |-> (($past(wt_pend_o) & wt_ack_o) != '0));

  // R3
  vr_ack_wt_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vr_ack_o) |-> ($past(wt_pend_o) == '0 && ($past(vr_pend_o) & vr_ack_o) != '0));

  // R3
  single_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wt_ack_o && |vr_ack_o));

  // R6
  stat_wt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stat_o[5] == (|wt_pend_o));

  // R6
  stat_vr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stat_o[6] == (|vr_pend_o));

  // R6
  irq_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_stat_o != 8'h00) && irq_stat_o[7] == 1'b0 && irq_stat_o[4:0] == 5'd0);
endmodule

bind voice_irq_queue voice_irq_queue_chk #(.NUM_VOICES(NUM_VOICES)) u_chk (.*);

// File: tb/voice_irq_queue_tb.sv
`timescale 1ns/1ps
module voice_irq_queue_tb;
  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fsel_we_i = 1'b0;
  logic [7:0]    fsel_data_i = '0;
  logic          ctrl_we_i = 1'b0;
  logic          ctrl_run_i = 1'b1;
  logic [NV-1:0] wt_set_i = '0, vr_set_i = '0;
  logic [NV-1:0] wt_pend_o, vr_pend_o, wt_ack_o, vr_ack_o;
  logic [7:0]    irq_id_o, irq_stat_o;
  logic          irq_o;

  always #10 clk = ~clk;

  voice_irq_queue u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fsel_we_i(fsel_we_i), .fsel_data_i(fsel_data_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_run_i(ctrl_run_i),
    .wt_set_i(wt_set_i), .vr_set_i(vr_set_i),
    .wt_pend_o(wt_pend_o), .vr_pend_o(vr_pend_o),
    .wt_ack_o(wt_ack_o), .vr_ack_o(vr_ack_o),
    .irq_id_o(irq_id_o), .irq_stat_o(irq_stat_o), .irq_o(irq_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [NV-1:0] m_wt = '0, m_vr = '0, m_awt = '0, m_avr = '0;
  logic [7:0]    m_id = 8'hE8;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NV-1:0] m);
    for (int v = 0; v < 31; v++) if (m[v]) return v;
    return -1;
  endfunction

  task automatic model_step(input logic [NV-1:0] ws, input logic [NV-1:0] vs,
                            input bit fwe, input logic [7:0] fd, input bit cwe, input bit run);
    int v;
    m_awt = '0; m_avr = '0;
    if (cwe && !run) begin
      m_wt = '0; m_vr = '0;
      return;
    end
    if (fwe && fd == 8'h8F) begin
      if (m_wt != '0) begin
        v = lowest(m_wt);
        if (v >= 0) begin
          m_wt[v] = 1'b0; m_awt[v] = 1'b1; m_id = 8'h60 | 8'(v);
        end else m_id = 8'hE8;
      end else if (m_vr != '0) begin
        v = lowest(m_vr);
        if (v >= 0) begin
          m_vr[v] = 1'b0; m_avr[v] = 1'b1; m_id = 8'h80 | 8'(v);
        end else m_id = 8'hE8;
      end else m_id = 8'hE8;
    end
    m_wt = m_wt | ws;
    m_vr = m_vr | vs;
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] es;
    es = {1'b0, |m_vr, |m_wt, 5'b0};
    chk(wt_pend_o == m_wt, {tag, " wt_pend"}, wt_pend_o, m_wt);
    chk(vr_pend_o == m_vr, {tag, " vr_pend"}, vr_pend_o, m_vr);
    chk(wt_ack_o == m_awt, {tag, " wt_ack"}, wt_ack_o, m_awt);
    chk(vr_ack_o == m_avr, {tag, " vr_ack"}, vr_ack_o, m_avr);
    chk(irq_id_o == m_id, {tag, " id"}, 32'(irq_id_o), 32'(m_id));
    chk(irq_stat_o == es, {tag, " R6 stat"}, 32'(irq_stat_o), 32'(es));
    chk(irq_o == (es != 0), {tag, " R6 irq"}, 32'(irq_o), 32'(es != 0));
  endtask

  // drive at negedge, compare at the next negedge
  task automatic step(input logic [NV-1:0] ws, input logic [NV-1:0] vs,
                      input bit fwe, input logic [7:0] fd, input bit cwe, input bit run,
                      input string tag);
    wt_set_i = ws; vr_set_i = vs; fsel_we_i = fwe; fsel_data_i = fd;
    ctrl_we_i = cwe; ctrl_run_i = run;
    model_step(ws, vs, fwe, fd, cwe, run);
    @(posedge clk);
    @(negedge clk);
    wt_set_i = '0; vr_set_i = '0; fsel_we_i = 1'b0; ctrl_we_i = 1'b0; ctrl_run_i = 1'b1;
    compare_all(tag);
  endtask

  task automatic deq(input string tag);
    step('0, '0, 1'b1, 8'h8F, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    // R9 reset state
    repeat (2) @(negedge clk);
    compare_all("R9");
    chk(irq_id_o == 8'hE8, "R9 id", 32'(irq_id_o), 32'h0E8);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4 empty dequeue
    deq("R4");
    chk(irq_id_o == 8'hE8, "R4 empty id", 32'(irq_id_o), 32'hE8);

    // R2 / R3 ordering
    step((NV'(1) << 3) | (NV'(1) << 9), NV'(1) << 2, 1'b0, 8'h00, 1'b0, 1'b1, "R7 set");
    deq("R2");
    chk(irq_id_o == 8'h63, "R2 first id", 32'(irq_id_o), 32'h63);
    deq("R2");
    chk(irq_id_o == 8'h69, "R2 second id", 32'(irq_id_o), 32'h69);
    chk(irq_stat_o[5] == 1'b0, "R6 wt summary cleared", 32'(irq_stat_o), 32'h40);
    deq("R3");
    chk(irq_id_o == 8'h82 && vr_ack_o == (NV'(1) << 2), "R3 vr id", 32'(irq_id_o), 32'h82);
    deq("R4");
    chk(irq_o == 1'b0, "R6 irq low", 32'(irq_o), 32'h0);

    // R1 non-dequeue writes
    step(NV'(1) << 5, '0, 1'b0, 8'h00, 1'b0, 1'b1, "R1 setup");
    step('0, '0, 1'b1, 8'h0F, 1'b0, 1'b1, "R1");
    step('0, '0, 1'b1, 8'h8E, 1'b0, 1'b1, "R1");
    chk(wt_pend_o == (NV'(1) << 5) && irq_id_o == 8'hE8, "R1 ignored", wt_pend_o, NV'(1) << 5);

    // R7 same-voice set during dequeue
    step(NV'(1) << 5, '0, 1'b1, 8'h8F, 1'b0, 1'b1, "R7");
    chk(wt_pend_o[5] && wt_ack_o == (NV'(1) << 5), "R7 set wins", wt_pend_o, NV'(1) << 5);
    deq("R2");

    // R5 only voice 31 pending
    step(NV'(1) << 31, NV'(1) << 4, 1'b0, 8'h00, 1'b0, 1'b1, "R5 setup");
    deq("R5");
    chk(irq_id_o == 8'hE8 && vr_pend_o == (NV'(1) << 4), "R5 stuck", 32'(irq_id_o), 32'hE8);

    // R8 flush
    step('0, '0, 1'b0, 8'h00, 1'b1, 1'b1, "R8 run=1");
    chk(wt_pend_o != '0, "R8 run=1 no effect", wt_pend_o, NV'(1) << 31);
    step(NV'(1) << 7, NV'(1) << 8, 1'b1, 8'h8F, 1'b1, 1'b0, "R8");
    chk(wt_pend_o == '0 && vr_pend_o == '0 && irq_stat_o == 8'h00, "R8 flushed",
        32'(irq_stat_o), 32'h0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [NV-1:0] ws, vs;
      bit fwe, cwe;
      logic [7:0] fd;
      ws  = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom & $urandom) : '0;
      vs  = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom & $urandom) : '0;
      fwe = ($urandom_range(0, 9) < 6);
      fd  = ($urandom_range(0, 9) < 7) ? 8'h8F : 8'($urandom);
      cwe = ($urandom_range(0, 99) < 2);
      step(ws, vs, fwe, fd, cwe, 1'($urandom), "R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule